// File: doc/BRIEF.md
# Multi-Input Edge Wakeup Controller

This block watches an 8-bit input port and records selected signal transitions, so that a sleeping core can be woken. Each pin has three bits of state. An active-low enable bit decides whether the pin may wake the core. A polarity bit picks the transition that counts, either low-to-high or high-to-low. A sticky pending flag records that the selected transition took place. The raw pins are first passed through a two-flop synchroniser. A transition is then found by comparing each synchronised sample with the sample from the cycle before.

Software reaches the three per-pin registers through an exchange with the working register. During one cycle it drives a mode code, the value to load and an exchange strobe. In that same cycle it receives the old contents of the selected register. Every exchange is accepted in the cycle it is presented, so there is no back-pressure and no handshake at this edge. The pending vector is also brought out on its own pins. The block raises a single wake request for the sleep sequencer whenever a pending pin is also enabled.

Top module: `pin_wake_ctrl`

## Requirements
- R1: During reset, and right after it, the enable and polarity registers hold FFh (all pins disabled, all pins set to high-to-low), the pending register holds 00h and wake_req is low.
- R2: When a pin's polarity bit is 0, a low-to-high change on that pin sets its pending bit. A pin level first sampled at clock edge k shows in pend_vec after edge k+2, and not after edge k+1.
- R3: When a pin's polarity bit is 1, a high-to-low change on that pin sets its pending bit, with the same latency as in R2.
- R4: A transition opposite to the selected one, or a steady pin, leaves the pin's pending bit unchanged.
- R5: A pending bit stays at 1 after the pin returns to its earlier level. Only a pending exchange that writes 0 to that bit clears it.
- R6: An exchange with mode code 09h (pending), 0Ah (polarity) or 0Bh (enable) returns the register's old contents on rd_data in the same cycle. The register holds wr_data after the next clock edge.
- R7: An exchange with any other mode code returns 00h and changes no register. rd_data is 00h whenever no exchange is presented.
- R8: If a pending exchange coincides with a newly detected selected transition on a pin, that pin's pending bit ends at 1, whatever value was written.
- R9: wake_req is high exactly when at least one pin has its pending bit at 1 and its enable bit at 0. A pending bit sets regardless of the enable bit.
- R10: Each pin is detected independently of the others. Several pins changing together each set their own bit according to their own polarity bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins | input | 8 | Asynchronous port pins to watch |
| xchg_en | input | 1 | Exchange strobe, one cycle per exchange |
| mode_sel | input | 4 | Mode code selecting the register (09h, 0Ah, 0Bh) |
| wr_data | input | 8 | Working register value to load |
| rd_data | output | 8 | Old register contents returned by the exchange |
| pend_vec | output | 8 | Pending flags, one per pin |
| wake_req | output | 1 | Request to leave power-down |

## Verification
The bench sweeps every pin against both polarities and both transition directions. It samples one cycle before and exactly at the expected latency, so a synchroniser that is one stage short or long shows up as a flag that appears too early or too late. A polarity decode that is inverted, or that ignores the register, would set flags on the wrong transitions. An exchange is timed to land in the very cycle a transition is detected: a design that lets the written value win would lose that event. The bench walks all 256 enable masks against computed pending patterns, which catches a wake request that is not gated by the enable bits or is gated with the wrong polarity. Every unused mode code is then tried, to catch decodes that alias into one of the three registers.

// File: rtl/wake_ctrl_pkg.sv
package wake_ctrl_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_PEND = 4'h9;
  localparam logic [MODE_W-1:0] MODE_POL  = 4'hA;
  localparam logic [MODE_W-1:0] MODE_ENB  = 4'hB;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_POL  = 2'd2,
    SEL_ENB  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_mode(input logic [MODE_W-1:0] m);
    case (m)
      MODE_PEND: return SEL_PEND;
      MODE_POL:  return SEL_POL;
      MODE_ENB:  return SEL_ENB;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic went_up, went_down;
      assign went_up   = level[i] & ~prev_q[i];
      assign went_down = prev_q[i] & ~level[i];
      assign hit[i]    = fall_sel[i] ? went_down : went_up;
    end
  endgenerate
endmodule

// File: rtl/wake_regfile.sv
module wake_regfile
  import wake_ctrl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xchg_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] hit,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] enb_n_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] pend_q
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic wr_pend, wr_pol, wr_enb;
  logic [W-1:0] pend_base;

  assign wr_pend = xchg_en && (sel == SEL_PEND);
  assign wr_pol  = xchg_en && (sel == SEL_POL);
  assign wr_enb  = xchg_en && (sel == SEL_ENB);

  // a fresh edge is ORed in after the written value, so the edge wins
  assign pend_base = wr_pend ? wr_data : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb_n_q <= ALL_ONES;
      pol_q   <= ALL_ONES;
      pend_q  <= '0;
    end else begin
      pend_q <= pend_base | hit;
      if (wr_pol) pol_q   <= wr_data;
      if (wr_enb) enb_n_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (xchg_en) begin
      case (sel)
        SEL_PEND: rd_data = pend_q;
        SEL_POL:  rd_data = pol_q;
        SEL_ENB:  rd_data = enb_n_q;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_wake_ctrl.sv
module pin_wake_ctrl
  import wake_ctrl_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  input  logic              xchg_en,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  output logic [PORT_W-1:0] pend_vec,
  output logic              wake_req
);
  logic [PORT_W-1:0] pin_s;
  logic [PORT_W-1:0] hit_vec;
  logic [PORT_W-1:0] enb_n_q, pol_q, pend_q;
  reg_sel_e          sel;

  assign sel = decode_mode(mode_sel);

  wake_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins),
    .q_sync  (pin_s)
  );

  wake_edge_det #(.W(PORT_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (pin_s),
    .fall_sel (pol_q),
    .hit      (hit_vec)
  );

  wake_regfile #(.W(PORT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .xchg_en (xchg_en),
    .sel     (sel),
    .wr_data (wr_data),
    .hit     (hit_vec),
    .rd_data (rd_data),
    .enb_n_q (enb_n_q),
    .pol_q   (pol_q),
    .pend_q  (pend_q)
  );

  assign pend_vec = pend_q;
  assign wake_req = |(pend_q & ~enb_n_q);
endmodule

// File: rtl/wake_ctrl_checker.sv
module wake_ctrl_checker
  import wake_ctrl_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xchg_en,
  input logic [MODE_W-1:0] mode_sel,
  input logic [PORT_W-1:0] wr_data,
  input logic [PORT_W-1:0] rd_data,
  input logic [PORT_W-1:0] pend_vec,
  input logic              wake_req,
  input logic [PORT_W-1:0] hit_vec
);
  logic pend_xchg, known_mode;
  assign pend_xchg  = xchg_en && (mode_sel == MODE_PEND);
  assign known_mode = (mode_sel == MODE_PEND) || (mode_sel == MODE_POL) || (mode_sel == MODE_ENB);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (!rst_n && !xchg_en) |=> (pend_vec == '0 && !wake_req)); // R1

  AST_NO_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_xchg && hit_vec == '0) |=> (pend_vec == $past(pend_vec))); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_xchg |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec))); // R5

  AST_XCHG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_xchg |=> ((pend_vec & $past(wr_data)) == $past(wr_data))); // R6

  AST_BAD_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!xchg_en || !known_mode) |-> (rd_data == '0)); // R7

  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_xchg |=> ((pend_vec & $past(hit_vec)) == $past(hit_vec))); // R8

  AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (pend_vec != '0)); // R9
endmodule

bind pin_wake_ctrl wake_ctrl_checker #(.PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xchg_en  (xchg_en),
  .mode_sel (mode_sel),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .pend_vec (pend_vec),
  .wake_req (wake_req),
  .hit_vec  (hit_vec)
);

// File: tb/pin_wake_ctrl_test.sv
`timescale 1ns/1ps
module pin_wake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       xchg_en = 1'b0;
  logic [3:0] mode_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, pend_vec;
  logic       wake_req;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pin_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .xchg_en(xchg_en),
    .mode_sel(mode_sel), .wr_data(wr_data), .rd_data(rd_data),
    .pend_vec(pend_vec), .wake_req(wake_req)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xchg(input logic [3:0] m, input logic [7:0] w, output logic [7:0] r);
    @(negedge clk);
    xchg_en = 1'b1; mode_sel = m; wr_data = w;
    #1 r = rd_data;
    @(negedge clk);
    xchg_en = 1'b0; mode_sel = '0; wr_data = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] exp;
    logic [7:0] pat;

    // R1 reset state
    wait_n(3);
    chk("R1 pend", pend_vec, 8'h00);
    chk("R1 wake", {7'b0, wake_req}, 8'h00);
    rst_n = 1'b1;
    wait_n(2);
    chk("R7 idle rd", rd_data, 8'h00);
    xchg(4'hB, 8'hFF, r); chk("R1 enable", r, 8'hFF);
    xchg(4'hA, 8'hFF, r); chk("R1 polarity", r, 8'hFF);
    xchg(4'h9, 8'h00, r); chk("R1 pending", r, 8'h00);

    // R2 R3 R4 per-pin sweep, enable left at FFh (R9: sets while disabled)
    for (int p = 0; p < 8; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int rise = 0; rise < 2; rise++) begin
          xchg(4'hA, {8{pol[0]}}, r);
          @(negedge clk);
          pins = rise[0] ? 8'h00 : 8'(1 << p);
          wait_n(4);
          xchg(4'h9, 8'h00, r);
          @(negedge clk);
          pins = pins ^ 8'(1 << p);
          wait_n(2);
          chk("R2 early", pend_vec, 8'h00);
          wait_n(1);
          exp = ((rise == 1 && pol == 0) || (rise == 0 && pol == 1)) ? 8'(1 << p) : 8'h00;
          if (pol == 0) chk("R2 R4 rise-select", pend_vec, exp);
          else          chk("R3 R4 fall-select", pend_vec, exp);
          chk("R9 disabled no wake", {7'b0, wake_req}, 8'h00);
          @(negedge clk);
          pins = 8'h00;
        end
      end
    end

    // R5 stickiness
    xchg(4'hA, 8'h00, r);
    wait_n(4);
    xchg(4'h9, 8'h00, r);
    @(negedge clk); pins = 8'h20;
    wait_n(3);
    chk("R5 set", pend_vec, 8'h20);
    @(negedge clk); pins = 8'h00;
    wait_n(5);
    chk("R5 held", pend_vec, 8'h20);
    xchg(4'h9, 8'h00, r);
    chk("R5 old value", r, 8'h20);
    chk("R5 cleared", pend_vec, 8'h00);

    // R8 exchange coincides with a detected edge
    @(negedge clk); pins = 8'h08;
    wait_n(2);
    xchg_en = 1'b1; mode_sel = 4'h9; wr_data = 8'h00;
    #1 chk("R8 read", rd_data, 8'h00);
    @(negedge clk);
    xchg_en = 1'b0; mode_sel = '0;
    chk("R8 edge wins", pend_vec, 8'h08);
    @(negedge clk); pins = 8'h00;
    wait_n(4);

    // R10 several pins at once, mixed polarity
    xchg(4'hA, 8'h0F, r);
    wait_n(4);
    xchg(4'h9, 8'h00, r);
    @(negedge clk); pins = 8'hFF;
    wait_n(3);
    chk("R10 rising group", pend_vec, 8'hF0);
    @(negedge clk); pins = 8'h00;
    wait_n(3);
    chk("R10 both groups", pend_vec, 8'hFF);
    wait_n(2);

    // R6 exchange returns old, loads new
    xchg(4'hB, 8'h3C, r); chk("R6 enable old", r, 8'hFF);
    xchg(4'hA, 8'hC3, r); chk("R6 polarity old", r, 8'h0F);
    xchg(4'h9, 8'h5A, r); chk("R6 pending old", r, 8'hFF);
    chk("R6 pending loaded", pend_vec, 8'h5A);

    // R7 unused mode codes
    for (int c = 0; c < 16; c++) begin
      if (c < 9 || c > 11) begin
        xchg(4'(c), 8'hA5, r);
        chk("R7 unused code read", r, 8'h00);
      end
    end
    xchg(4'hB, 8'h3C, r); chk("R7 enable kept", r, 8'h3C);
    xchg(4'hA, 8'hC3, r); chk("R7 polarity kept", r, 8'hC3);
    xchg(4'h9, 8'h5A, r); chk("R7 pending kept", r, 8'h5A);

    // R9 wake gating over every enable mask
    for (int m = 0; m < 256; m++) begin
      pat = 8'(m * 37) ^ 8'hA5;
      xchg(4'hB, 8'(m), r);
      xchg(4'h9, pat, r);
      exp = {7'b0, |(pat & ~8'(m))};
      chk("R9 wake", {7'b0, wake_req}, exp);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule